// File: doc/BRIEF.md
# Configurable GPIO Port Bank

This block is one bank of general-purpose pins, 24 wide by default, set up through a small 32-bit register interface. Five registers control each pin. The output data register holds the value to drive. The direction register enables the driver. The alternate-source register lets another on-chip module supply the data for that pin. The open-drain register turns the pin into a pull-low-only output. The invert register flips the final driven value. A write to the data address loads the output register. A read from the data address returns the pin levels, after they have passed through a two-flop synchronizer.

The bank drives a value and an output enable for each pin toward the tristate pad cells. A safe-state strobe, normally from a watchdog, forces every pin back to input by clearing the direction and open-drain registers. The other registers keep their values, so software can bring the pins back without reloading any data.

Top module: `gpio_bank`

## Requirements
- R1: While rst_ni is low, every register is 0, pad_oe_o is all 0 and bus_rdata_o reads 0 at every register address.
- R2: A write to address 0 loads the output data register. A read of address 0 returns the synchronized pin levels in bits 23:0 and 0 in bits 31:24. A pin change reaches the read data after the second rising clock edge.
- R3: Addresses 1, 2, 3 and 4 read back the direction, alternate-source, open-drain and invert registers in bits 23:0, with 0 in the upper bits. Addresses 5 to 7 read 0, and writes to them change no register.
- R4: For a pin that is not open-drain, pad_oe_o equals its direction bit and pad_o equals its final value.
- R5: A pin whose alternate-source bit is 1 takes its pre-inversion value from alt_i. Otherwise it takes it from the output data register.
- R6: An invert bit of 1 inverts the value after the source select. The value read back from the pins is never inverted.
- R7: For an open-drain pin, pad_o is 0 and pad_oe_o is 1 exactly when the final value is 0. The direction bit has no effect on that pin.
- R8: When safe_i is high at a rising edge, the direction and open-drain registers become 0 at that edge, even if a write to either register occurs in the same cycle. The output data, alternate-source and invert registers keep their values.
- R9: A register write changes pad_o and pad_oe_o from the next rising edge on. alt_i, by contrast, reaches pad_o and pad_oe_o in the same cycle, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| safe_i | input | 1 | Safe-state strobe: clears direction and open-drain |
| pin_i | input | 24 | Pin levels from the pads |
| alt_i | input | 24 | Alternate data source for each pin |
| pad_o | output | 24 | Value driven toward each pad |
| pad_oe_o | output | 24 | Output enable for each pad |

## Verification
Register readback and alt_i are combinational. They are therefore checked in the cycle they are applied, a few nanoseconds after inputs change, with no edge in between. A register write is due on pad_o and pad_oe_o one rising edge later. A pin change is due in the data read two edges later: the check one edge after the change still expects the old level, and the check after the second edge expects the new one. The reference model advances its synchronizer and registers on every rising edge. It is compared on every falling edge, so each of these latencies is tested every cycle during a long random run.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_DATA   = 3'd0;
  localparam logic [ADDR_W-1:0] A_DIR    = 3'd1;
  localparam logic [ADDR_W-1:0] A_ALT    = 3'd2;
  localparam logic [ADDR_W-1:0] A_ODRAIN = 3'd3;
  localparam logic [ADDR_W-1:0] A_INV    = 3'd4;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 24,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_bank_pkg::*;
#(
  parameter int unsigned WIDTH  = 24,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WIDTH-1:0]  wdata_i,
  input  logic              safe_i,
  input  logic [WIDTH-1:0]  pin_sync_i,
  output logic [WIDTH-1:0]  out_q_o,
  output logic [WIDTH-1:0]  dir_q_o,
  output logic [WIDTH-1:0]  alt_q_o,
  output logic [WIDTH-1:0]  od_q_o,
  output logic [WIDTH-1:0]  inv_q_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned PAD_W = DATA_W - WIDTH;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q_o <= '0;
      alt_q_o <= '0;
      inv_q_o <= '0;
    end else if (wr_i) begin
      if (addr_i == A_DATA) out_q_o <= wdata_i;
      if (addr_i == A_ALT)  alt_q_o <= wdata_i;
      if (addr_i == A_INV)  inv_q_o <= wdata_i;
    end
  end

  // safe-state has priority over a same-cycle write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q_o <= '0;
      od_q_o  <= '0;
    end else if (safe_i) begin
      dir_q_o <= '0;
      od_q_o  <= '0;
    end else if (wr_i) begin
      if (addr_i == A_DIR)    dir_q_o <= wdata_i;
      if (addr_i == A_ODRAIN) od_q_o  <= wdata_i;
    end
  end

  logic [WIDTH-1:0] rsel;
  always_comb begin
    case (addr_i)
      A_DATA:   rsel = pin_sync_i;
      A_DIR:    rsel = dir_q_o;
      A_ALT:    rsel = alt_q_o;
      A_ODRAIN: rsel = od_q_o;
      A_INV:    rsel = inv_q_o;
      default:  rsel = '0;
    endcase
  end

  assign rdata_o = {{PAD_W{1'b0}}, rsel};
endmodule

// File: rtl/gpio_drive.sv
module gpio_drive #(
  parameter int unsigned WIDTH = 24
) (
  input  logic [WIDTH-1:0] out_q_i,
  input  logic [WIDTH-1:0] alt_i,
  input  logic [WIDTH-1:0] dir_q_i,
  input  logic [WIDTH-1:0] alt_q_i,
  input  logic [WIDTH-1:0] od_q_i,
  input  logic [WIDTH-1:0] inv_q_i,
  output logic [WIDTH-1:0] pad_o,
  output logic [WIDTH-1:0] pad_oe_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic src, fin;
    assign src = alt_q_i[b] ? alt_i[b] : out_q_i[b];
    assign fin = src ^ inv_q_i[b];
    // open-drain: drive low only, direction ignored
    assign pad_o[b]    = od_q_i[b] ? 1'b0 : fin;
    assign pad_oe_o[b] = od_q_i[b] ? ~fin : dir_q_i[b];
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned WIDTH       = 24,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic              safe_i,
  input  logic [WIDTH-1:0]  pin_i,
  input  logic [WIDTH-1:0]  alt_i,
  output logic [WIDTH-1:0]  pad_o,
  output logic [WIDTH-1:0]  pad_oe_o
);
  logic [WIDTH-1:0] pin_sync, out_q, dir_q, alt_q, od_q, inv_q;
  logic unused_wdata;
  assign unused_wdata = ^bus_wdata_i[DATA_W-1:WIDTH];

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_sync)
  );

  gpio_regs #(.WIDTH(WIDTH), .DATA_W(DATA_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (bus_wr_i),
    .addr_i    (bus_addr_i),
    .wdata_i   (bus_wdata_i[WIDTH-1:0]),
    .safe_i    (safe_i),
    .pin_sync_i(pin_sync),
    .out_q_o   (out_q),
    .dir_q_o   (dir_q),
    .alt_q_o   (alt_q),
    .od_q_o    (od_q),
    .inv_q_o   (inv_q),
    .rdata_o   (bus_rdata_o)
  );

  gpio_drive #(.WIDTH(WIDTH)) u_drive (
    .out_q_i (out_q),
    .alt_i   (alt_i),
    .dir_q_i (dir_q),
    .alt_q_i (alt_q),
    .od_q_i  (od_q),
    .inv_q_i (inv_q),
    .pad_o   (pad_o),
    .pad_oe_o(pad_oe_o)
  );
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int unsigned WIDTH = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              safe_i,
  input logic              wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [WIDTH-1:0]  wdata_i,
  input logic [WIDTH-1:0]  pin_i,
  input logic [WIDTH-1:0]  pad_o,
  input logic [WIDTH-1:0]  pad_oe_o,
  input logic [WIDTH-1:0]  dir_q,
  input logic [WIDTH-1:0]  od_q,
  input logic [WIDTH-1:0]  sync_q
);
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) age_q <= '0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end

  assert_safe_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    safe_i |=> (dir_q == '0) && (od_q == '0));

  assert_dir_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == A_DIR && !safe_i) |=> dir_q == $past(wdata_i));

  assert_od_never_high_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_o & pad_oe_o & od_q) == '0);

  assert_oe_follows_dir_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pad_oe_o ^ dir_q) & ~od_q) == '0);

  assert_sync_delay_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd2) |-> sync_q == $past(pin_i, 2));
endmodule

bind gpio_bank gpio_bank_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .safe_i  (safe_i),
  .wr_i    (bus_wr_i),
  .addr_i  (bus_addr_i),
  .wdata_i (bus_wdata_i[WIDTH-1:0]),
  .pin_i   (pin_i),
  .pad_o   (pad_o),
  .pad_oe_o(pad_oe_o),
  .dir_q   (dir_q),
  .od_q    (od_q),
  .sync_q  (pin_sync)
);

// File: tb/gpio_bank_tb.sv
module gpio_bank_tb;
  localparam int W = 24;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0, safe = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, rdata;
  logic [W-1:0] pin = '0, alt = '0, pad, pad_oe;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gpio_bank u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(rdata), .safe_i(safe),
    .pin_i(pin), .alt_i(alt), .pad_o(pad), .pad_oe_o(pad_oe)
  );

  // reference model
  logic [W-1:0] m_out, m_dir, m_alt, m_od, m_inv, m_s1, m_s2;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_out <= '0; m_dir <= '0; m_alt <= '0; m_od <= '0; m_inv <= '0;
      m_s1 <= '0; m_s2 <= '0;
    end else begin
      m_s1 <= pin;
      m_s2 <= m_s1;
      if (bus_wr) begin
        if (bus_addr == 3'd0) m_out <= bus_wdata[W-1:0];
        if (bus_addr == 3'd1) m_dir <= bus_wdata[W-1:0];
        if (bus_addr == 3'd2) m_alt <= bus_wdata[W-1:0];
        if (bus_addr == 3'd3) m_od  <= bus_wdata[W-1:0];
        if (bus_addr == 3'd4) m_inv <= bus_wdata[W-1:0];
      end
      if (safe) begin m_dir <= '0; m_od <= '0; end
    end
  end

  function automatic logic [31:0] exp_rd();
    case (bus_addr)
      3'd0: return {8'h0, m_s2};
      3'd1: return {8'h0, m_dir};
      3'd2: return {8'h0, m_alt};
      3'd3: return {8'h0, m_od};
      3'd4: return {8'h0, m_inv};
      default: return 32'h0;
    endcase
  endfunction

  task automatic exp_pad(output logic [W-1:0] p, output logic [W-1:0] oe);
    for (int b = 0; b < W; b++) begin
      logic v;
      v = (m_alt[b] ? alt[b] : m_out[b]) ^ m_inv[b];
      if (m_od[b]) begin p[b] = 1'b0; oe[b] = !v; end
      else begin p[b] = v; oe[b] = m_dir[b]; end
    end
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [W-1:0] ep, eoe;
      exp_pad(ep, eoe);
      chk("R4 R5 R6 R7 R9 pad_o", {8'h0, pad}, {8'h0, ep});
      chk("R4 R7 R9 pad_oe_o", {8'h0, pad_oe}, {8'h0, eoe});
      chk((bus_addr == 0) ? "R2 rdata" : "R3 rdata", rdata, exp_rd());
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected<=100000 cycles", cyc);
      summary();
    end
  end

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); #1;
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); #1;
    bus_wr = 0;
  endtask

  task automatic rd(logic [2:0] a, logic [31:0] exp, string tag);
    #1 bus_addr = a;
    #1 chk(tag, rdata, exp);
  endtask

  initial begin
    pin = '1;
    repeat (2) @(negedge clk);
    chk("R1 pad_oe_o in reset", {8'h0, pad_oe}, 32'h0);
    for (int a = 0; a < 5; a++) rd(3'(a), 32'h0, "R1 rdata in reset");
    #1 rst_n = 1;
    pin = '0;

    wr(3'd1, 32'h0000_00ff);
    chk("R9 oe one edge after dir write", {8'h0, pad_oe}, 32'h0000_00ff);
    wr(3'd0, 32'hffff_ffa5);
    chk("R4 pad_o follows data", {24'h0, pad[7:0]}, 32'ha5);
    chk("R4 pad_oe_o follows dir", {8'h0, pad_oe}, 32'hff);

    wr(3'd2, 32'h0f);
    alt = 24'h000003; #1;
    chk("R5 R9 alt source same cycle", {24'h0, pad[7:0]}, 32'ha3);

    wr(3'd4, 32'hffffff);
    chk("R6 invert after mux", {24'h0, pad[7:0]}, 32'h5c);
    pin = 24'h123456;
    bus_addr = 3'd0;
    @(negedge clk); #2;
    chk("R2 one edge: old level", rdata, 32'h0);
    @(negedge clk); #2;
    chk("R2 R6 two edges: new level, not inverted", rdata, 32'h0012_3456);

    wr(3'd3, 32'hff);
    chk("R7 od low bits oe", {24'h0, pad_oe[7:0]}, 32'ha3);
    chk("R7 od pad low", {24'h0, pad[7:0]}, 32'h0);
    wr(3'd1, 32'h0);
    chk("R7 dir ignored", {24'h0, pad_oe[7:0]}, 32'ha3);

    wr(3'd1, 32'hffff00);
    @(negedge clk); #1;
    bus_wr = 1; bus_addr = 3'd1; bus_wdata = 32'hffffff; safe = 1;
    @(negedge clk); #1;
    bus_wr = 0; safe = 0;
    rd(3'd1, 32'h0, "R8 dir cleared over write");
    rd(3'd3, 32'h0, "R8 od cleared");
    rd(3'd4, 32'hffffff, "R8 inv kept");
    rd(3'd2, 32'h0f, "R8 alt kept");

    wr(3'd6, 32'hffffffff);
    rd(3'd6, 32'h0, "R3 unmapped reads 0");
    rd(3'd4, 32'hffffff, "R3 unmapped write ignored");
    rd(3'd1, 32'h0, "R3 unmapped write ignored dir");

    for (int i = 0; i < 3000; i++) begin
      @(negedge clk); #1;
      bus_wr    = ($urandom % 3) == 0;
      bus_addr  = 3'($urandom % 8);
      bus_wdata = $urandom;
      safe      = ($urandom % 40) == 0;
      pin       = W'($urandom);
      alt       = W'($urandom);
    end
    @(negedge clk); #1;
    bus_wr = 0; safe = 0;
    @(negedge clk); #1;
    summary();
  end
endmodule